// File: doc/BRIEF.md
# Double-Buffered Clock-Synchronous Serial Transmitter

This block sends bytes on a serial data line together with a serial clock. Software writes a byte into a holding register. While the block is enabled, the byte moves into a shift register, and the block clocks out one bit on each falling edge of the serial clock, least significant bit first. A receiver samples each bit on the rising edge. The serial clock comes from one of two places: a programmable divider of the system clock, or an external clock pin, which passes through a synchroniser first.

Two flags report progress. The first says the holding register is empty. The second says the transmission has finished. A new byte written before the last bit of a frame is sent follows that frame with no idle gap. If no byte is waiting, the line stops: the serial clock idles high and the data line holds the last bit. Each flag drives a level interrupt through its own enable. Any receive error flag that is raised stops a new frame from starting.

Top module: `sync_ser_tx`

## Requirements
- R1: A write (wr_valid high while cfg_tx_en is high) stores wr_data in the holding register and clears hold_empty and tx_end in the next cycle. If the block is idle, enabled and no receive error is raised, the cycle after that moves the byte into the shift register and sets hold_empty to 1.
- R2: Data bits leave on sdata_out least significant bit first. sdata_out changes only in the cycle in which sclk_out falls. In internal clock mode every sclk_out level lasts cfg_div+1 system cycles, so one bit lasts 2*(cfg_div+1) cycles.
- R3: At the rising serial clock edge that ends the last data bit, the block checks the holding register. If a byte is waiting, it is loaded and its first bit follows one half-period later, so chained frames have no gap and tx_end stays 0.
- R4: If no byte is waiting at that edge, tx_end becomes 1, sclk_out stays high and sdata_out keeps the level of the last bit sent.
- R5: While any of rx_err_ovr, rx_err_frm or rx_err_par is 1, no frame starts: neither from idle nor chained. A pending byte stays pending (hold_empty 0) and goes out once all three are 0.
- R6: irq_empty equals hold_empty AND cfg_txi_en. irq_end equals tx_end AND cfg_tei_en. Both are levels.
- R7: With cfg_ext_sel at 1, shifting follows ext_sclk_in instead. Each falling edge of ext_sclk_in sends the next bit, and each rising edge ends a bit, after a two-stage synchroniser. No bit moves while ext_sclk_in stays constant.
- R8: While cfg_tx_en is 0, the shifter is stopped, sclk_out is high, hold_empty and tx_end are 1, and writes are ignored. A write made while disabled sends nothing after the block is enabled again.
- R9: After reset, sclk_out, sdata_out, hold_empty and tx_end are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_ext_sel | input | 1 | 1: serial clock from ext_sclk_in; 0: internal divider |
| cfg_div | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cfg_txi_en | input | 1 | Enable for irq_empty |
| cfg_tei_en | input | 1 | Enable for irq_end |
| wr_valid | input | 1 | Holding-register write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rx_err_ovr | input | 1 | Receive overrun error flag |
| rx_err_frm | input | 1 | Receive framing error flag |
| rx_err_par | input | 1 | Receive parity error flag |
| ext_sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Serial clock, idles high |
| sdata_out | output | 1 | Serial data |
| hold_empty | output | 1 | Holding register empty flag |
| tx_end | output | 1 | Transmission finished flag |
| irq_empty | output | 1 | Holding-empty interrupt level |
| irq_end | output | 1 | Transmit-end interrupt level |

## Verification
The properties rely on four things. cfg_div and cfg_ext_sel change only while the line is idle. ext_sclk_in idles high and holds each level for at least three system cycles. The receive error inputs are steady levels. wr_valid is a single-cycle strobe. The stimulus keeps to these rules: it changes configuration only after tx_end has risen, drives the external clock with eight-cycle half-periods starting from high, and raises or drops error flags between clock cycles without pulsing them.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

endpackage

// File: rtl/sst_clkgen.sv
// Serial clock event generator: internal divider or synchronised external pin.
module sst_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_sclk,
    input  logic             sclk_lvl,
    output logic             fall_evt,
    output logic             rise_evt
);

    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [SW-1:0]    sync;
    } cg_t;

    cg_t  cg_d, cg_q;
    logic tick;
    logic ext_rise;
    logic ext_fall;

    always_comb begin
        cg_d      = cg_q;
        cg_d.sync = {cg_q.sync[SW-2:0], ext_sclk};
        tick      = run && (cg_q.cnt == div);
        if (!run || tick) begin
            cg_d.cnt = '0;
        end else begin
            cg_d.cnt = cg_q.cnt + DIV_W'(1);
        end
        ext_rise = cg_q.sync[SW-2] & ~cg_q.sync[SW-1];
        ext_fall = ~cg_q.sync[SW-2] & cg_q.sync[SW-1];
        fall_evt = run & sclk_lvl  & (ext_sel ? ext_fall : tick);
        rise_evt = run & ~sclk_lvl & (ext_sel ? ext_rise : tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cg_q.cnt  <= '0;
            cg_q.sync <= '1;
        end else begin
            cg_q <= cg_d;
        end
    end

endmodule

// File: rtl/sst_shifter.sv
// Shift register with bit index; emits LSB first on each shift strobe.
module sst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sdata,
    output logic              last
);

    localparam int                CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] tsr;
        logic [CNT_W-1:0]  idx;
        logic              sd;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tsr = load_data;
            sh_d.idx = LAST_IDX;
        end else if (shift) begin
            sh_d.sd  = sh_q.tsr[0];
            sh_d.tsr = sh_q.tsr >> 1;
            sh_d.idx = (sh_q.idx == LAST_IDX) ? '0 : sh_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.tsr <= '0;
            sh_q.idx <= LAST_IDX;
            sh_q.sd  <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata = sh_q.sd;
    assign last  = (sh_q.idx == LAST_IDX);

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_ext_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_txi_en,
    input  logic              cfg_tei_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_err_ovr,
    input  logic              rx_err_frm,
    input  logic              rx_err_par,
    input  logic              ext_sclk_in,
    output logic              sclk_out,
    output logic              sdata_out,
    output logic              hold_empty,
    output logic              tx_end,
    output logic              irq_empty,
    output logic              irq_end
);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              done;
        logic              sclk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rx_err;
    logic run;
    logic load;
    logic fall_evt;
    logic rise_evt;
    logic last_bit;
    logic ser_bit;

    assign rx_err = rx_err_ovr | rx_err_frm | rx_err_par;
    assign run    = (ctl_q.st == TX_RUN) & cfg_tx_en;

    sst_clkgen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ext_sel (cfg_ext_sel),
        .div     (cfg_div),
        .ext_sclk(ext_sclk_in),
        .sclk_lvl(ctl_q.sclk),
        .fall_evt(fall_evt),
        .rise_evt(rise_evt)
    );

    sst_shifter #(
        .DATA_W(DATA_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_data(ctl_q.hold),
        .shift    (fall_evt),
        .sdata    (ser_bit),
        .last     (last_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        if (!cfg_tx_en) begin
            ctl_d.st    = TX_IDLE;
            ctl_d.sclk  = 1'b1;
            ctl_d.empty = 1'b1;
            ctl_d.done  = 1'b1;
        end else begin
            case (ctl_q.st)
                TX_IDLE: begin
                    if (!ctl_q.empty && !rx_err) begin
                        load        = 1'b1;
                        ctl_d.empty = 1'b1;
                        ctl_d.done  = 1'b0;
                        ctl_d.st    = TX_RUN;
                    end
                end
                TX_RUN: begin
                    if (fall_evt) begin
                        ctl_d.sclk = 1'b0;
                    end
                    if (rise_evt) begin
                        ctl_d.sclk = 1'b1;
                        if (last_bit) begin
                            if (!ctl_q.empty && !rx_err) begin
                                load        = 1'b1;
                                ctl_d.empty = 1'b1;
                            end else begin
                                ctl_d.st   = TX_IDLE;
                                ctl_d.done = 1'b1;
                            end
                        end
                    end
                end
                default: ctl_d.st = TX_IDLE;
            endcase
            if (wr_valid) begin
                ctl_d.hold  = wr_data;
                ctl_d.empty = 1'b0;
                ctl_d.done  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= TX_IDLE;
            ctl_q.hold  <= '0;
            ctl_q.empty <= 1'b1;
            ctl_q.done  <= 1'b1;
            ctl_q.sclk  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk_out   = ctl_q.sclk;
    assign sdata_out  = ser_bit;
    assign hold_empty = ctl_q.empty;
    assign tx_end     = ctl_q.done;
    assign irq_empty  = ctl_q.empty & cfg_txi_en;
    assign irq_end    = ctl_q.done & cfg_tei_en;

endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_tx_en,
    input logic wr_valid,
    input logic rx_err_ovr,
    input logic rx_err_frm,
    input logic rx_err_par,
    input logic sclk_out,
    input logic sdata_out,
    input logic hold_empty,
    input logic tx_end
);

    logic any_err;
    assign any_err = rx_err_ovr | rx_err_frm | rx_err_par;

    // R4
    end_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> sclk_out);

    // R2
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_out) |-> $fell(sclk_out));

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en |=> (hold_empty && tx_end && sclk_out));

    // R1
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_en && wr_valid) |=> (!hold_empty && !tx_end));

    // R5
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_en && any_err && !hold_empty) |=> !hold_empty);

endmodule

bind sync_ser_tx sst_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_tx_en (cfg_tx_en),
    .wr_valid  (wr_valid),
    .rx_err_ovr(rx_err_ovr),
    .rx_err_frm(rx_err_frm),
    .rx_err_par(rx_err_par),
    .sclk_out  (sclk_out),
    .sdata_out (sdata_out),
    .hold_empty(hold_empty),
    .tx_end    (tx_end)
);

// File: tb/sync_ser_tx_tb.sv
`timescale 1ns/1ps
module sync_ser_tx_tb;

    localparam int W  = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, ext_sel = 1'b0, txi_en = 1'b0, tei_en = 1'b0;
    logic [DW-1:0] div = '0;
    logic          wr_valid = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          e_ovr = 1'b0, e_frm = 1'b0, e_par = 1'b0;
    logic          ext_clk = 1'b1;
    logic          sclk_out, sdata_out, hold_empty, tx_end, irq_empty, irq_end;

    always #2 clk = ~clk;

    sync_ser_tx #(.DATA_W(W), .DIV_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(tx_en), .cfg_ext_sel(ext_sel),
        .cfg_div(div), .cfg_txi_en(txi_en), .cfg_tei_en(tei_en),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rx_err_ovr(e_ovr), .rx_err_frm(e_frm), .rx_err_par(e_par),
        .ext_sclk_in(ext_clk), .sclk_out(sclk_out), .sdata_out(sdata_out),
        .hold_empty(hold_empty), .tx_end(tx_end),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit model_on = 1'b1;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Behavioural reference model, updated once per clock.
    bit           m_run, m_empty, m_end, m_sclk, m_sd, m_err, m_e0;
    int           m_t, m_idx, m_p;
    logic [W-1:0] m_byte, m_tdr;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=completion");
            summary();
            $finish;
        end
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_byte = '0; m_tdr = '0;
            m_empty = 1; m_end = 1; m_sclk = 1; m_sd = 1;
        end else if (!tx_en) begin
            m_run = 0; m_sclk = 1; m_empty = 1; m_end = 1;
        end else begin
            m_err = e_ovr | e_frm | e_par;
            m_e0  = m_empty;
            m_p   = int'(div) + 1;
            if (!m_run) begin
                if (!m_e0 && !m_err) begin
                    m_run = 1; m_t = 0; m_byte = m_tdr; m_empty = 1; m_end = 0;
                end
            end else begin
                m_t++;
                if (m_t % m_p == 0) begin
                    m_idx = m_t / m_p - 1;
                    if (m_idx % 2 == 0) begin
                        m_sclk = 0;
                        m_sd   = m_byte[m_idx/2];
                    end else begin
                        m_sclk = 1;
                        if (m_idx == 2*W - 1) begin
                            if (!m_e0 && !m_err) begin
                                m_byte = m_tdr; m_empty = 1; m_t = 0;
                            end else begin
                                m_run = 0; m_end = 1;
                            end
                        end
                    end
                end
            end
            if (wr_valid) begin
                m_tdr = wr_data; m_empty = 0; m_end = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R2 sclk_out vs model", sclk_out, m_sclk);
            chk("R2 sdata_out vs model", sdata_out, m_sd);
            chk("R1 hold_empty vs model", hold_empty, m_empty);
            chk("R4 tx_end vs model", tx_end, m_end);
            chk("R6 irq_empty vs model", irq_empty, m_empty & txi_en);
            chk("R6 irq_end vs model", irq_end, m_end & tei_en);
        end
    end

    // Line monitor: bits captured on serial clock rising edges.
    logic prev_sclk = 1'b1;
    bit   bitq[$];
    int   n_fall = 0, first_fall = 0, last_rise = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sclk && !sclk_out) begin
                n_fall++;
                if (n_fall == 1) first_fall = cyc;
            end
            if (!prev_sclk && sclk_out) begin
                bitq.push_back(sdata_out);
                last_rise = cyc;
            end
        end
        prev_sclk = sclk_out;
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic put(input logic [W-1:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        step(1);
        wr_valid = 1'b0;
    endtask

    task automatic wait_end(input int max);
        for (int i = 0; i < max; i++) begin
            if (tx_end) break;
            step(1);
        end
    endtask

    function automatic logic [W-1:0] pop_byte();
        logic [W-1:0] b = '0;
        for (int i = 0; i < W; i++) begin
            if (bitq.size() > 0) b[i] = bitq.pop_front();
            else b[i] = 1'bx;
        end
        return b;
    endfunction

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        chk("R9 sclk after reset", sclk_out, 1);
        chk("R9 sdata after reset", sdata_out, 1);
        chk("R9 hold_empty after reset", hold_empty, 1);
        chk("R9 tx_end after reset", tx_end, 1);

        tx_en = 1; div = 8'd2; txi_en = 1; tei_en = 1;
        step(2);

        // R1, R3: two chained frames
        n_fall = 0;
        bitq.delete();
        put(8'hA5);
        chk("R1 hold_empty cleared by write", hold_empty, 0);
        chk("R1 tx_end cleared by write", tx_end, 0);
        step(1);
        chk("R1 hold_empty set on load", hold_empty, 1);
        put(8'h3C);
        wait_end(400);
        step(1);
        chk("R2 first byte LSB first", pop_byte(), 8'hA5);
        chk("R3 chained byte", pop_byte(), 8'h3C);
        chk("R3 fall count for two frames", n_fall, 2*W);
        chk("R3 no gap between frames", last_rise - first_fall, (4*W - 1) * 3);

        // R4: line holds last bit, clock idles high
        div = 8'd0;
        step(1);
        put(8'h81);
        wait_end(200);
        step(10);
        chk("R4 data holds bit7=1", sdata_out, 1);
        chk("R4 clock idles high", sclk_out, 1);
        put(8'h01);
        wait_end(200);
        step(10);
        chk("R4 data holds bit7=0", sdata_out, 0);
        chk("R2 byte 0x01", (bitq.size() >= 2*W) ? 1 : 0, 1);
        bitq.delete();

        // R5: error blocks start
        div = 8'd1;
        e_par = 1;
        n_fall = 0;
        put(8'h55);
        step(30);
        chk("R5 start blocked: hold_empty", hold_empty, 0);
        chk("R5 start blocked: no clock", n_fall, 0);
        e_par = 0;
        wait_end(10);
        wait_end(300);
        step(2);
        chk("R5 byte after error cleared", pop_byte(), 8'h55);

        // R5: error blocks chaining
        put(8'h0F);
        step(2);
        put(8'hF0);
        step(10);
        e_ovr = 1;
        wait_end(300);
        step(2);
        chk("R5 chain blocked: tx_end", tx_end, 1);
        chk("R5 chain blocked: hold_empty", hold_empty, 0);
        e_ovr = 0;
        step(2);
        wait_end(300);
        step(2);
        chk("R5 frame before block", pop_byte(), 8'h0F);
        chk("R5 frame after release", pop_byte(), 8'hF0);

        // R6: interrupt gating
        txi_en = 0;
        step(1);
        chk("R6 irq_empty masked", irq_empty, 0);
        tei_en = 0;
        step(1);
        chk("R6 irq_end masked", irq_end, 0);
        txi_en = 1; tei_en = 1;
        step(1);
        chk("R6 irq_empty level", irq_empty, 1);
        chk("R6 irq_end level", irq_end, 1);

        // R8: disable mid-frame, writes ignored
        put(8'h77);
        step(10);
        tx_en = 0;
        step(1);
        chk("R8 hold_empty when disabled", hold_empty, 1);
        chk("R8 tx_end when disabled", tx_end, 1);
        chk("R8 clock high when disabled", sclk_out, 1);
        put(8'h12);
        step(2);
        chk("R8 write ignored while disabled", hold_empty, 1);
        tx_en = 1;
        n_fall = 0;
        step(20);
        chk("R8 nothing sent after re-enable", n_fall, 0);
        chk("R8 still empty after re-enable", hold_empty, 1);
        bitq.delete();

        // R7: external clock
        model_on = 0;
        ext_sel = 1;
        ext_clk = 1;
        step(4);
        put(8'hC6);
        step(20);
        chk("R7 no shifting without external edges", n_fall, 0);
        chk("R7 loaded", hold_empty, 1);
        for (int i = 0; i < W; i++) begin
            ext_clk = 0;
            step(8);
            ext_clk = 1;
            step(8);
        end
        step(6);
        chk("R7 tx_end after external frame", tx_end, 1);
        chk("R7 clock high after external frame", sclk_out, 1);
        chk("R7 byte on external clock", pop_byte(), 8'hC6);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule